// File: doc/BRIEF.md
# Platform Sleep-State Power Controller

This block is the state machine that moves a processor platform between its power states. There are four resting states: hard-off (G3), soft-off (S5), suspend (S3) and run (S0). Six transitional states join them. The machine watches two inputs from the platform: a power-good level from the PMIC, and a processor wake level that is high whenever the processor is not suspended. It also takes a force-shutdown request, a power-on request and a few flags that are sampled once at reset. The block does not switch the rails itself. It asks an external rail sequencer to run one of four step tables, using a one-cycle start and a done pulse.

On a cold start the machine pulses the PMIC enable line if power-good is missing. It then asks for a controller self-reset unless the controller is already running its primary image. After that it waits a bounded time for power-good. A forced shutdown holds the PMIC key line low until power-good drops, and only then returns to hard-off. A run flag is raised while the processor runs, so that the controller can keep itself out of deep sleep. Time is counted in milliseconds from a 1 kHz tick enable.

Top module: `plat_pwr_ctrl`

## Requirements
- R1: While `rst_n` is low, `state_o` is 0 (G3), and `run_flag`, `seq_start`, `self_rst_req` and `pmic_en` are all 0. The state codes are G3=0, S5=1, S3=2, S0=3, G3S5=4, S5S3=5, S3S0=6, S0S3=7, S3S5=8, S5G3=9.
- R2: Once the input synchronizer has filled after reset, the block makes its boot decision. If `warm_start`, power-good and the wake level are all high, it enters S0 with `run_flag` high. Otherwise it stays in G3, and it leaves G3 on its own only when `warm_start` and `stay_off` are both low. In G3, an `on_req` pulse moves it to G3S5.
- R3: Entering G3S5 clears any pending force request. If power-good is low, `pmic_en` goes high for `PULSE_MS` ticks and then returns low.
- R4: In G3S5, a low `primary_img` raises `self_rst_req`. The request stays high, and the state stays in G3S5, until reset. With `primary_img` high, power-good seen within `PG_TMO_MS` ticks leads to S5; otherwise the block returns to G3.
- R5: In S5 with no force request, the next state is S5S3. With a force request, `pmic_en` is driven low while power-good is high. Once power-good is low, `pmic_en` goes high and the state becomes S5G3.
- R6: In S3, a loss of power-good or a pending force request leads to S3S5. Otherwise, a high wake level leads to S3S0, and a low one keeps the block in S3.
- R7: In S0, a loss of power-good, a force request or a low wake level leads to S0S3. While none of these is present the block stays in S0.
- R8: In S3S0, after the sequence is done, power-good seen before `PG_TMO_MS` ticks leads to S0 with `run_flag` high. On timeout the force request is set, the next state is S0S3, and `run_flag` stays low.
- R9: Each of S5S3, S3S0, S0S3 and S3S5 pulses `seq_start` for exactly one cycle, with `seq_sel` set to 0, 1, 2 or 3 in that order. The state then waits for `seq_done`.
- R10: `run_flag` stays high through S0S3 and drops when that state's sequence is done. It is never high outside S0 and S0S3.
- R11: S5G3 moves to G3 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_ms | input | 1 | One-cycle 1 kHz time base enable |
| pg_in | input | 1 | PMIC power-good (asynchronous) |
| awake_in | input | 1 | High when the processor is not suspended (asynchronous) |
| force_req | input | 1 | Pulse that requests a forced shutdown |
| on_req | input | 1 | Pulse that requests power-on from G3 |
| primary_img | input | 1 | Controller is running its primary image |
| warm_start | input | 1 | Reset was a warm jump, sampled at boot |
| stay_off | input | 1 | Suppress auto power-on at cold boot |
| seq_done | input | 1 | Rail sequencer finished the requested table |
| seq_start | output | 1 | One-cycle start to the rail sequencer |
| seq_sel | output | 2 | Table to run: 0 S5S3, 1 S3S0, 2 S0S3, 3 S3S5 |
| pmic_en | output | 1 | PMIC enable / power-key line level |
| self_rst_req | output | 1 | Request to reset the controller into its primary image |
| state_o | output | 4 | Current state code |
| run_flag | output | 1 | Processor running, blocks deep sleep |

## Verification
The bench builds the block with `PG_TMO_MS`=4, `PULSE_MS`=3 and `SYNC_STAGES`=2. With timeouts this short, it can sweep the arrival of power-good over every tick position around the limit, both in G3S5 and in S3S0. It also covers all sixteen combinations of the boot inputs. In the S0 sweep, each pass uses a different cause to leave run: a low wake level, a loss of power-good, or a force request. This drives every exit from S0 and S3, and both endings of a forced S5.

// File: rtl/ppc_pkg.sv
package ppc_pkg;

   typedef enum logic [3:0] {
      PS_G3   = 4'd0,
      PS_S5   = 4'd1,
      PS_S3   = 4'd2,
      PS_S0   = 4'd3,
      PS_G3S5 = 4'd4,
      PS_S5S3 = 4'd5,
      PS_S3S0 = 4'd6,
      PS_S0S3 = 4'd7,
      PS_S3S5 = 4'd8,
      PS_S5G3 = 4'd9
   } pstate_e;

   typedef enum logic [2:0] {
      PH_ENTRY,
      PH_PULSE,
      PH_IMAGE,
      PH_SEQ,
      PH_PGWAIT
   } phase_e;

   typedef enum logic [1:0] {
      TBL_S5S3 = 2'd0,
      TBL_S3S0 = 2'd1,
      TBL_S0S3 = 2'd2,
      TBL_S3S5 = 2'd3
   } table_e;

   function automatic table_e tbl_of(input pstate_e s);
      case (s)
         PS_S3S0: return TBL_S3S0;
         PS_S0S3: return TBL_S0S3;
         PS_S3S5: return TBL_S3S5;
         default: return TBL_S5S3;
      endcase
   endfunction

endpackage

// File: rtl/ppc_sync.sv
module ppc_sync #(
   parameter int unsigned W      = 2,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES == 0) begin : g_bypass
      assign q = d;
   end else begin : g_chain
      logic [W-1:0] r [STAGES];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) r[i] <= '0;
         end else begin
            r[0] <= d;
            for (int i = 1; i < STAGES; i++) r[i] <= r[i-1];
         end
      end
      assign q = r[STAGES-1];
   end
endmodule

// File: rtl/ppc_mscnt.sv
module ppc_mscnt #(
   parameter int unsigned MAXV = 100,
   parameter int unsigned CW   = $clog2(MAXV + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          tick,
   output logic [CW-1:0] cnt
);
   localparam logic [CW-1:0] LIMIT = CW'(MAXV);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    cnt <= '0;
      else if (clr)                  cnt <= '0;
      else if (tick && cnt != LIMIT) cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/plat_pwr_ctrl.sv
module plat_pwr_ctrl
   import ppc_pkg::*;
#(
   parameter int unsigned PG_TMO_MS   = 100,
   parameter int unsigned PULSE_MS    = 50,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick_ms,
   input  logic       pg_in,
   input  logic       awake_in,
   input  logic       force_req,
   input  logic       on_req,
   input  logic       primary_img,
   input  logic       warm_start,
   input  logic       stay_off,
   input  logic       seq_done,
   output logic       seq_start,
   output logic [1:0] seq_sel,
   output logic       pmic_en,
   output logic       self_rst_req,
   output logic [3:0] state_o,
   output logic       run_flag
);
   localparam int unsigned CMAX = (PG_TMO_MS > PULSE_MS) ? PG_TMO_MS : PULSE_MS;
   localparam int unsigned CW   = $clog2(CMAX + 1);
   localparam int unsigned BW   = $clog2(SYNC_STAGES + 1) + 1;

   if (PG_TMO_MS < 1 || PULSE_MS < 1) begin : g_bad_time
      $error("plat_pwr_ctrl: PG_TMO_MS and PULSE_MS must be at least 1");
   end
   if (SYNC_STAGES > 4) begin : g_bad_sync
      $error("plat_pwr_ctrl: SYNC_STAGES must not exceed 4");
   end

   logic pg_s, awake_s;
   ppc_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({pg_in, awake_in}),
      .q     ({pg_s, awake_s})
   );

   pstate_e st_q, st_d;
   phase_e  ph_q, ph_d;
   table_e  sel_q, sel_d;
   logic    force_q, force_d, onpend_q, onpend_d, run_q, run_d;
   logic    pmic_q, pmic_d, srst_q, srst_d, start_q, start_d;
   logic    boot_act;
   logic [BW-1:0] boot_cnt;
   logic [CW-1:0] cnt;
   logic    cnt_clr, boot_ready, pulse_done, pg_tmo;

   ppc_mscnt #(.MAXV(CMAX), .CW(CW)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (cnt_clr),
      .tick  (tick_ms),
      .cnt   (cnt)
   );

   assign boot_ready = (boot_cnt == BW'(SYNC_STAGES));
   assign pulse_done = (cnt >= CW'(PULSE_MS));
   assign pg_tmo     = (cnt >= CW'(PG_TMO_MS));
   assign cnt_clr    = (st_d != st_q) || (ph_d != ph_q);

   always_comb begin
      st_d     = st_q;
      ph_d     = ph_q;
      sel_d    = sel_q;
      force_d  = force_q | force_req;
      onpend_d = onpend_q;
      run_d    = run_q;
      pmic_d   = pmic_q;
      srst_d   = srst_q;
      start_d  = 1'b0;
      if (boot_act) begin
         force_d = 1'b0;
         if (boot_ready) begin
            if (warm_start && pg_s && awake_s) begin
               st_d  = PS_S0;
               run_d = 1'b1;
            end else if (!warm_start && !stay_off) begin
               onpend_d = 1'b1;
            end
         end
      end else begin
         case (st_q)
            PS_G3:
               if (onpend_q || on_req) st_d = PS_G3S5;
            PS_G3S5: begin
               case (ph_q)
                  PH_ENTRY: begin
                     force_d  = 1'b0;
                     onpend_d = 1'b0;
                     if (!pg_s) begin
                        pmic_d = 1'b1;
                        ph_d   = PH_PULSE;
                     end else begin
                        ph_d   = PH_IMAGE;
                     end
                  end
                  PH_PULSE:
                     if (pulse_done) begin
                        pmic_d = 1'b0;
                        ph_d   = PH_IMAGE;
                     end
                  PH_IMAGE:
                     if (!primary_img) srst_d = 1'b1;
                     else              ph_d   = PH_PGWAIT;
                  PH_PGWAIT:
                     if (pg_s)        st_d = PS_S5;
                     else if (pg_tmo) st_d = PS_G3;
                  default: ph_d = PH_ENTRY;
               endcase
            end
            PS_S5:
               if (!force_q) begin
                  st_d = PS_S5S3;
               end else if (pg_s) begin
                  pmic_d = 1'b0;
               end else begin
                  pmic_d = 1'b1;
                  st_d   = PS_S5G3;
               end
            PS_S3:
               if (!pg_s || force_q) st_d = PS_S3S5;
               else if (awake_s)     st_d = PS_S3S0;
            PS_S0:
               if (!pg_s || force_q || !awake_s) st_d = PS_S0S3;
            PS_S5S3, PS_S3S0, PS_S0S3, PS_S3S5: begin
               case (ph_q)
                  PH_ENTRY: begin
                     start_d = 1'b1;
                     sel_d   = tbl_of(st_q);
                     ph_d    = PH_SEQ;
                  end
                  PH_SEQ:
                     if (seq_done && !start_q) begin
                        case (st_q)
                           PS_S5S3: st_d = PS_S3;
                           PS_S3S0: ph_d = PH_PGWAIT;
                           PS_S0S3: begin
                              st_d  = PS_S3;
                              run_d = 1'b0;
                           end
                           default: st_d = PS_S5;
                        endcase
                     end
                  PH_PGWAIT:
                     if (pg_s) begin
                        st_d  = PS_S0;
                        run_d = 1'b1;
                     end else if (pg_tmo) begin
                        force_d = 1'b1;
                        st_d    = PS_S0S3;
                     end
                  default: ph_d = PH_ENTRY;
               endcase
            end
            PS_S5G3: st_d = PS_G3;
            default: st_d = PS_G3;
         endcase
         if (st_d != st_q) ph_d = PH_ENTRY;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q     <= PS_G3;
         ph_q     <= PH_ENTRY;
         sel_q    <= TBL_S5S3;
         force_q  <= 1'b0;
         onpend_q <= 1'b0;
         run_q    <= 1'b0;
         pmic_q   <= 1'b0;
         srst_q   <= 1'b0;
         start_q  <= 1'b0;
         boot_act <= 1'b1;
         boot_cnt <= '0;
      end else begin
         st_q     <= st_d;
         ph_q     <= ph_d;
         sel_q    <= sel_d;
         force_q  <= force_d;
         onpend_q <= onpend_d;
         run_q    <= run_d;
         pmic_q   <= pmic_d;
         srst_q   <= srst_d;
         start_q  <= start_d;
         if (boot_act) begin
            if (boot_ready) boot_act <= 1'b0;
            else            boot_cnt <= boot_cnt + 1'b1;
         end
      end
   end

   assign state_o      = st_q;
   assign seq_start    = start_q;
   assign seq_sel      = sel_q;
   assign pmic_en      = pmic_q;
   assign self_rst_req = srst_q;
   assign run_flag     = run_q;

endmodule

// File: rtl/ppc_chk.sv
module ppc_chk
   import ppc_pkg::*;
(
   input logic       clk,
   input logic       rst_n,
   input logic       seq_start,
   input logic [1:0] seq_sel,
   input logic       run_flag,
   input logic       self_rst_req,
   input logic [3:0] state_o
);
   AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      seq_start |=> !seq_start); // R9

   AST_START_IN_TRANSIT: assert property (@(posedge clk) disable iff (!rst_n)
      seq_start |-> (state_o inside {4'(PS_S5S3), 4'(PS_S3S0), 4'(PS_S0S3), 4'(PS_S3S5)})); // R9

   AST_WAKE_TABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (seq_start && state_o == 4'(PS_S3S0)) |-> seq_sel == 2'd1); // R9

   AST_RUN_SCOPE: assert property (@(posedge clk) disable iff (!rst_n)
      run_flag |-> (state_o == 4'(PS_S0) || state_o == 4'(PS_S0S3))); // R10

   AST_S0_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == 4'(PS_S0)) |-> run_flag); // R8

   AST_S5G3_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == 4'(PS_S5G3)) |=> (state_o == 4'(PS_G3))); // R11

   AST_SELF_RESET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      self_rst_req |=> (self_rst_req && state_o == 4'(PS_G3S5))); // R4

endmodule

bind plat_pwr_ctrl ppc_chk u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .seq_start    (seq_start),
   .seq_sel      (seq_sel),
   .run_flag     (run_flag),
   .self_rst_req (self_rst_req),
   .state_o      (state_o)
);

// File: tb/tb_plat_pwr_ctrl.sv
module tb_plat_pwr_ctrl;
   localparam int CLK_PERIOD = 10;
   localparam int TMO  = 4;
   localparam int PUL  = 3;
   localparam int SYNC = 2;
   localparam logic [3:0] G3 = 4'd0, S5 = 4'd1, S3 = 4'd2, S0 = 4'd3, G3S5 = 4'd4,
                          S5S3 = 4'd5, S3S0 = 4'd6, S0S3 = 4'd7, S3S5 = 4'd8, S5G3 = 4'd9;

   logic clk = 1'b0, rst_n = 1'b0, tick_ms = 1'b0, pg_in = 1'b0, awake_in = 1'b0;
   logic force_req = 1'b0, on_req = 1'b0, primary_img = 1'b1, warm_start = 1'b0;
   logic stay_off = 1'b1, seq_done = 1'b0;
   logic seq_start, pmic_en, self_rst_req, run_flag;
   logic [1:0] seq_sel;
   logic [3:0] state_o;

   int checks = 0, errors = 0, wd = 0;
   bit finished = 0;

   plat_pwr_ctrl #(.PG_TMO_MS(TMO), .PULSE_MS(PUL), .SYNC_STAGES(SYNC)) dut (
      .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .pg_in(pg_in), .awake_in(awake_in),
      .force_req(force_req), .on_req(on_req), .primary_img(primary_img),
      .warm_start(warm_start), .stay_off(stay_off), .seq_done(seq_done),
      .seq_start(seq_start), .seq_sel(seq_sel), .pmic_en(pmic_en),
      .self_rst_req(self_rst_req), .state_o(state_o), .run_flag(run_flag));

   always #(CLK_PERIOD/2) clk = ~clk;

   always @(posedge clk) begin
      wd++;
      if (wd > 100000 && !finished) begin
         finished = 1;
         errors++;
         $display("FAIL watchdog R1 actual %0d cycles expected below 100000", wd);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic tick1();
      tick_ms = 1'b1; cyc(1);
      tick_ms = 1'b0; cyc(1);
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) tick1();
   endtask

   task automatic expect_state(input logic [3:0] s, input int maxc, input string tag);
      bit found = 0;
      for (int i = 0; i < maxc && !found; i++) begin
         if (state_o == s) found = 1;
         else cyc(1);
      end
      chk(found, tag, int'(state_o), int'(s));
   endtask

   task automatic wait_start(output bit found);
      found = 0;
      for (int i = 0; i < 60 && !found; i++) begin
         if (seq_start) found = 1;
         else cyc(1);
      end
   endtask

   task automatic give_done();
      cyc(2); seq_done = 1'b1; cyc(1); seq_done = 1'b0;
   endtask

   task automatic serve(input logic [1:0] sel, input logic [3:0] st, input string tag);
      bit found;
      wait_start(found);
      chk(found && seq_sel == sel && state_o == st, tag, int'(seq_sel), int'(sel));
      give_done();
   endtask

   task automatic do_reset(input bit w, input bit p, input bit a, input bit so, input bit pi);
      warm_start = w; pg_in = p; awake_in = a; stay_off = so; primary_img = pi;
      rst_n = 1'b0; cyc(3);
      chk(state_o == G3 && !run_flag && !seq_start && !self_rst_req && !pmic_en,
          "R1 reset outputs", int'(state_o), 0);
      rst_n = 1'b1;
   endtask

   // from S3 or from a forced S5 with power-good still high, down to G3
   task automatic shutdown(input bit pulse_force);
      if (pulse_force) begin
         force_req = 1'b1; cyc(1); force_req = 1'b0;
         serve(2'd3, S3S5, "R6 force request in S3 gives S3S5 (R9 table 3)");
      end
      expect_state(S5, 20, "R5 forced shutdown reaches S5");
      cyc(6);
      chk(state_o == S5 && pmic_en == 1'b0, "R5 key held low while power-good high",
          int'(pmic_en), 0);
      pg_in = 1'b0;
      expect_state(S5G3, 20, "R5 power-good loss gives S5G3");
      chk(pmic_en == 1'b1, "R5 key released", int'(pmic_en), 1);
      cyc(1);
      chk(state_o == G3, "R11 S5G3 moves to G3", int'(state_o), int'(G3));
   endtask

   // from G3 with power-good low; power-good arrives after k ticks
   task automatic power_k(input int k);
      on_req = 1'b1; cyc(1); on_req = 1'b0;
      expect_state(G3S5, 10, "R2 power-on request leaves G3");
      cyc(1);
      chk(pmic_en == 1'b1, "R3 enable pulse starts", int'(pmic_en), 1);
      ticks(PUL - 1);
      chk(pmic_en == 1'b1 && state_o == G3S5, "R3 pulse lasts PULSE_MS ticks", int'(pmic_en), 1);
      tick1();
      chk(pmic_en == 1'b0, "R3 pulse ends", int'(pmic_en), 0);
      cyc(3);
      ticks(k);
      if (k < TMO) begin
         pg_in = 1'b1;
         serve(2'd0, S5S3, "R5 unforced S5 goes to S5S3 (R4 power-good in time, R9 table 0)");
         expect_state(S3, 20, "R4 power-good in time reaches S3");
         cyc(8);
         chk(state_o == S3, "R6 suspended stays in S3", int'(state_o), int'(S3));
      end else begin
         expect_state(G3, 4, "R4 power-good timeout returns to G3");
      end
   endtask

   // from S3 with power-good high and wake low; power-good restored after k ticks
   task automatic run_k(input int k);
      bit found;
      int cause;
      awake_in = 1'b1;
      wait_start(found);
      chk(found && seq_sel == 2'd1 && state_o == S3S0, "R6 wake in S3 gives S3S0 (R9 table 1)",
          int'(state_o), int'(S3S0));
      pg_in = 1'b0; cyc(4);
      seq_done = 1'b1; cyc(1); seq_done = 1'b0;
      cyc(3);
      ticks(k);
      if (k < TMO) begin
         pg_in = 1'b1;
         expect_state(S0, 10, "R8 power-good in time enters S0");
         chk(run_flag == 1'b1, "R8 run flag raised in S0", int'(run_flag), 1);
         cyc(6);
         chk(state_o == S0, "R7 S0 held while conditions hold", int'(state_o), int'(S0));
         cause = k % 3;
         if (cause == 0) awake_in = 1'b0;
         else if (cause == 1) pg_in = 1'b0;
         else begin force_req = 1'b1; cyc(1); force_req = 1'b0; end
         expect_state(S0S3, 10, "R7 exit condition leaves S0");
         chk(run_flag == 1'b1, "R10 run flag held in S0S3", int'(run_flag), 1);
         awake_in = 1'b0; pg_in = 1'b1;
         serve(2'd2, S0S3, "R9 S0S3 uses table 2");
         expect_state(S3, 10, "R10 S0S3 done gives S3");
         chk(run_flag == 1'b0, "R10 run flag cleared", int'(run_flag), 0);
         if (cause == 2) begin
            serve(2'd3, S3S5, "R6 pending force in S3 gives S3S5");
            shutdown(1'b0);
            power_k(0);
         end else begin
            cyc(8);
            chk(state_o == S3, "R6 suspended S3 holds", int'(state_o), int'(S3));
         end
      end else begin
         expect_state(S0S3, 4, "R8 timeout gives S0S3");
         chk(run_flag == 1'b0, "R8 run flag low after timeout", int'(run_flag), 0);
         awake_in = 1'b0;
         serve(2'd2, S0S3, "R9 S0S3 table after timeout");
         serve(2'd3, S3S5, "R8 timeout force flag leads S3 to S3S5");
         expect_state(G3, 20, "R5 forced S5 without power-good ends in G3");
         chk(pmic_en == 1'b1, "R5 key line high after forced shutdown", int'(pmic_en), 1);
         power_k(0);
      end
   endtask

   initial begin
      cyc(2);
      // boot decision over all 16 combinations of the boot inputs
      for (int v = 0; v < 16; v++) begin
         bit w, p, a, so;
         w = v[0]; p = v[1]; a = v[2]; so = v[3];
         do_reset(w, p, a, so, 1'b1);
         cyc(8);
         if (w && p && a)
            chk(state_o == S0 && run_flag, "R2 warm start with rails up enters S0",
                int'(state_o), int'(S0));
         else if (!w && !so)
            chk(state_o != G3, "R2 cold auto power-on leaves G3", int'(state_o), int'(G3S5));
         else begin
            chk(state_o == G3, "R2 no auto power-on stays in G3", int'(state_o), int'(G3));
            on_req = 1'b1; cyc(1); on_req = 1'b0; cyc(2);
            chk(state_o == G3S5, "R2 power-on request from G3", int'(state_o), int'(G3S5));
         end
      end

      // self-reset request when not running the primary image
      do_reset(1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
      cyc(12);
      chk(self_rst_req == 1'b1 && state_o == G3S5, "R4 self-reset request raised",
          int'(self_rst_req), 1);
      cyc(10);
      chk(self_rst_req == 1'b1 && state_o == G3S5, "R4 self-reset request held",
          int'(state_o), int'(G3S5));

      // cold boot sweep: power-good arrival tick against the timeout
      do_reset(1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
      cyc(6);
      for (int k = 0; k <= TMO + 1; k++) begin
         power_k(k);
         if (k < TMO) shutdown(1'b1);
      end

      // S3S0 sweep with each exit cause from S0
      power_k(0);
      for (int k = 0; k <= TMO; k++) run_k(k);

      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule